// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time as six packed-BCD byte fields: seconds, minutes, hours (24-hour), day of month, month and two-digit year (00 to 99, standing for 2000 to 2099). A single-cycle `tick_1hz` pulse advances the seconds field. Any carry ripples through minutes, hours, day, month and year within that same clock cycle. The day field follows month length, and February has 29 days whenever the year is a multiple of four.

Software reaches the block through a flat byte register port with a single-cycle write strobe and a combinational read. The six time fields are loaded only while the run bit is clear, so software stops the clock, writes all six fields and then restarts it. Reads of the time fields never return the live counters. They return a set of snapshot latches, refreshed when software sets the capture bit, so a multi-byte read cannot tear across a carry. Six alarm bytes are compared with the live time. When the live time becomes equal to the alarm, a sticky flag is set. The flag is cleared by writing a one back to it, and it pulls the active-low level interrupt when the alarm interrupt is enabled.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the time latches read sec 0x00, min 0x00, hour 0x00, day 0x01, month 0x01 and year 0x00. The control register (0x10) reads 0x00, the alarm flag is 0 and `irq_n` is 1.
- R2: While run (control bit 0) is 1, each `tick_1hz` pulse advances seconds by one in BCD. Seconds 0x59 wraps to 0x00 and carries into minutes, minutes 0x59 wraps to 0x00 and carries into hours, and hour 0x23 wraps to 0x00 and carries into the day, all in the same cycle.
- R3: A carry out of the last day of the month sets day to 0x01 and increments the month. The last day is 0x31 for months 01, 03, 05, 07, 08, 10 and 12, and 0x30 for months 04, 06, 09 and 11. For February it is 0x29 when the year is divisible by 4 and 0x28 otherwise.
- R4: A carry out of month 0x12 sets month to 0x01 and increments the year. Year 0x99 wraps to 0x00.
- R5: While run is 0, ticks have no effect, and a write to addresses 0x00 to 0x05 (sec, min, hour, day, month, year, in that order) loads that live field. While run is 1, such writes are ignored.
- R6: Writing 1 to control bit 1 (capture) copies all six live fields into the read latches on the next clock edge. Reads of 0x00 to 0x05 return the latches, which do not change with ticks until the next capture.
- R7: The capture bit reads back as 1 until the copy is made and clears itself on that same edge. The run bit keeps the value last written.
- R8: Alarm bytes at 0x08 to 0x0D use the same field order and encoding and read back as written. Status bit 0 (address 0x11) is set when the live time changes to a value equal to all six alarm bytes.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A fresh match in the same cycle as the clear wins.
- R10: `irq_n` is 0 exactly while the alarm flag is 1 and interrupt-enable bit 0 (address 0x12) is 1. Otherwise it is 1, while the flag itself still sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (5) | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Alarm interrupt, active low, level |

## Verification
The bench aims at the rollover edges: seconds, minutes and hours carrying together, the last day of 30-day and 31-day months, February in leap and common years, and the wrap from 99-12-31 to 00-01-01. A design with a wrong carry chain or month-length table would show a skipped or extra day, an invalid BCD digit or a stale month there. It also writes the time while the clock runs, ticks after a capture, and clears the alarm flag by writing 0 and then 1. A design that honoured running writes, let the latches follow the counters, or cleared the flag on any write would give a mismatching readback. The alarm is checked with the interrupt enabled and disabled, which catches an `irq_n` that ignores the enable or never asserts.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 6;
  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DAY = 3;
  localparam int F_MON = 4;
  localparam int F_YR  = 5;

  typedef logic [7:0] bcd_t;
  typedef logic [NFIELD-1:0][7:0] cal_t;

  localparam cal_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_bcd(input bcd_t yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic bcd_t last_day(input bcd_t mon, input bcd_t yr);
    case (mon)
      8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              adv,
  input  logic [NFIELD-1:0] ld_en,
  input  bcd_t              ld_data,
  output cal_t              cur
);
  cal_t cur_q, cur_d;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    cur_d = cur_q;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    if (|ld_en) begin
      for (int i = 0; i < NFIELD; i++)
        if (ld_en[i]) cur_d[i] = ld_data;
    end else if (adv) begin
      c_min = (cur_q[F_SEC] == 8'h59);
      cur_d[F_SEC] = c_min ? 8'h00 : bcd_inc(cur_q[F_SEC]);
      if (c_min) begin
        c_hr = (cur_q[F_MIN] == 8'h59);
        cur_d[F_MIN] = c_hr ? 8'h00 : bcd_inc(cur_q[F_MIN]);
      end
      if (c_hr) begin
        c_day = (cur_q[F_HR] == 8'h23);
        cur_d[F_HR] = c_day ? 8'h00 : bcd_inc(cur_q[F_HR]);
      end
      if (c_day) begin
        c_mon = (cur_q[F_DAY] == last_day(cur_q[F_MON], cur_q[F_YR]));
        cur_d[F_DAY] = c_mon ? 8'h01 : bcd_inc(cur_q[F_DAY]);
      end
      if (c_mon) begin
        c_yr = (cur_q[F_MON] == 8'h12);
        cur_d[F_MON] = c_yr ? 8'h01 : bcd_inc(cur_q[F_MON]);
      end
      if (c_yr) begin
        cur_d[F_YR] = (cur_q[F_YR] == 8'h99) ? 8'h00 : bcd_inc(cur_q[F_YR]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cur_q <= CAL_RESET;
    else         cur_q <= cur_d;
  end

  assign cur = cur_q;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  cal_t              live,
  input  logic [NFIELD-1:0] al_wr,
  input  bcd_t              al_data,
  input  logic              flag_clr,
  output cal_t              al_val,
  output logic              flag
);
  cal_t al_q;
  logic [NFIELD-1:0] fld_eq;
  logic match, match_q, flag_q, flag_d;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)       al_q[g] <= 8'h00;
      else if (al_wr[g]) al_q[g] <= al_data;
    end
    assign fld_eq[g] = (live[g] == al_q[g]);
  end

  assign match = &fld_eq;

  always_comb begin
    flag_d = flag_q;
    if (flag_clr)           flag_d = 1'b0;
    if (match && !match_q)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= match;
      flag_q  <= flag_d;
    end
  end

  assign al_val = al_q;
  assign flag   = flag_q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq_n
);
  localparam logic [AW-1:0] A_TIME = AW'(5'h00);
  localparam logic [AW-1:0] A_ALRM = AW'(5'h08);
  localparam logic [AW-1:0] A_CTRL = AW'(5'h10);
  localparam logic [AW-1:0] A_STAT = AW'(5'h11);
  localparam logic [AW-1:0] A_IEN  = AW'(5'h12);

  logic rst_sn;
  logic run_q, run_d, get_q, get_d, ien_q, ien_d;
  logic [NFIELD-1:0] time_sel, alrm_sel, time_wr, alrm_wr;
  logic flag, flag_clr;
  cal_t live_time, snap_q, al_val;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  for (genvar g = 0; g < NFIELD; g++) begin : g_dec
    assign time_sel[g] = (addr == A_TIME + AW'(g));
    assign alrm_sel[g] = (addr == A_ALRM + AW'(g));
    assign time_wr[g]  = wr_en && time_sel[g] && !run_q;
    assign alrm_wr[g]  = wr_en && alrm_sel[g];
  end

  always_comb begin
    run_d = run_q;
    get_d = get_q;
    ien_d = ien_q;
    if (get_q) get_d = 1'b0;
    if (wr_en && addr == A_CTRL) begin
      run_d = wdata[0];
      if (wdata[1]) get_d = 1'b1;
    end
    if (wr_en && addr == A_IEN) ien_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q <= 1'b0;
      get_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      run_q <= run_d;
      get_q <= get_d;
      ien_q <= ien_d;
    end
  end

  assign flag_clr = wr_en && (addr == A_STAT) && wdata[0];

  rtc_time_chain u_chain (
    .clk(clk), .rst_sn(rst_sn),
    .adv(tick_1hz && run_q),
    .ld_en(time_wr), .ld_data(wdata),
    .cur(live_time)
  );

  for (genvar g = 0; g < NFIELD; g++) begin : g_snap
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)    snap_q[g] <= CAL_RESET[g];
      else if (get_q) snap_q[g] <= live_time[g];
    end
  end

  rtc_alarm_unit u_alarm (
    .clk(clk), .rst_sn(rst_sn),
    .live(live_time),
    .al_wr(alrm_wr), .al_data(wdata),
    .flag_clr(flag_clr),
    .al_val(al_val), .flag(flag)
  );

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NFIELD; i++) begin
      if (time_sel[i]) rdata = snap_q[i];
      if (alrm_sel[i]) rdata = al_val[i];
    end
    if (addr == A_CTRL) rdata = {6'b0, get_q, run_q};
    if (addr == A_STAT) rdata = {7'b0, flag};
    if (addr == A_IEN)  rdata = {7'b0, ien_q};
  end

  assign irq_n = !(flag && ien_q);
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              get_q,
  input logic [NFIELD-1:0] time_wr,
  input cal_t              live_time,
  input cal_t              snap_q,
  input logic              flag,
  input logic              irq_n
);
  assert_halted_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && time_wr == '0) |=> $stable(live_time));

  assert_sec_bcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_time[F_SEC] <= 8'h59) && (live_time[F_SEC][3:0] <= 4'd9));

  assert_hour_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_time[F_HR] <= 8'h23) && (live_time[F_HR][3:0] <= 4'd9));

  assert_month_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_time[F_MON] >= 8'h01) && (live_time[F_MON] <= 8'h12));

  assert_get_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    get_q |=> !get_q);

  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !get_q |=> $stable(snap_q));

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> flag);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .get_q(get_q),
  .time_wr(time_wr), .live_time(live_time), .snap_q(snap_q),
  .flag(flag), .irq_n(irq_n)
);

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int n_run = 0, n_fail = 0;
  int m_s, m_mi, m_h, m_d, m_mo, m_y;

  always #4 clk = ~clk;

  rtc_calendar dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (act timeout, exp completion)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [7:0] b2bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [47:0] model_bcd();
    return {b2bcd(m_y), b2bcd(m_mo), b2bcd(m_d), b2bcd(m_h), b2bcd(m_mi), b2bcd(m_s)};
  endfunction

  task automatic model_tick();
    m_s++;
    if (m_s == 60) begin m_s = 0; m_mi++; end
    if (m_mi == 60) begin m_mi = 0; m_h++; end
    if (m_h == 24) begin m_h = 0; m_d++; end
    if (m_d > mdays(m_mo, m_y)) begin m_d = 1; m_mo++; end
    if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
  endtask

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_time(output logic [47:0] t);
    logic [7:0] b;
    for (int i = 0; i < 6; i++) begin
      rd(5'(i), b);
      t[i*8 +: 8] = b;
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      if (dut.run_q) model_tick();
    end
  endtask

  task automatic set_time(input int y, input int mo, input int d,
                          input int h, input int mi, input int s);
    wr(5'h10, 8'h00);
    wr(5'h00, b2bcd(s));  wr(5'h01, b2bcd(mi)); wr(5'h02, b2bcd(h));
    wr(5'h03, b2bcd(d));  wr(5'h04, b2bcd(mo)); wr(5'h05, b2bcd(y));
    m_y = y; m_mo = mo; m_d = d; m_h = h; m_mi = mi; m_s = s;
    wr(5'h10, 8'h01);
  endtask

  task automatic snap_check(input string req);
    logic [47:0] t;
    wr(5'h10, 8'h03);
    rd_time(t);
    chk(req, t, model_bcd());
  endtask

  initial begin
    logic [47:0] t, t0;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_time(t);
    chk("R1 time latches", t, {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
    rd(5'h10, b); chk("R1 ctrl", 48'(b), 48'h00);
    rd(5'h11, b); chk("R1 flag", 48'(b), 48'h00);
    chk("R1 irq_n", 48'(irq_n), 48'h1);

    // R5 halted: ticks ignored
    m_y = 0; m_mo = 1; m_d = 1; m_h = 0; m_mi = 0; m_s = 0;
    tick(3);
    wr(5'h10, 8'h02); rd_time(t);
    chk("R5 ticks ignored while halted", t, model_bcd());

    // R2 sec/min/hour carry in one tick
    set_time(24, 6, 10, 22, 59, 59); tick(1); snap_check("R2 hour carry");
    set_time(24, 6, 10, 23, 59, 58); tick(2); snap_check("R2 day carry");
    // R3 month lengths
    set_time(23, 4, 30, 23, 59, 59); tick(1); snap_check("R3 30-day month");
    set_time(23, 1, 31, 23, 59, 59); tick(1); snap_check("R3 31-day month");
    set_time(24, 2, 28, 23, 59, 59); tick(1); snap_check("R3 leap Feb 29");
    tick(86400 / 86400); snap_check("R3 leap Feb 29 run");
    set_time(24, 2, 29, 23, 59, 59); tick(1); snap_check("R3 leap Feb end");
    set_time(23, 2, 28, 23, 59, 59); tick(1); snap_check("R3 common Feb end");
    set_time(0, 2, 28, 23, 59, 59); tick(1); snap_check("R3 year 00 leap");
    // R4 year wrap
    set_time(99, 12, 31, 23, 59, 59); tick(1); snap_check("R4 99 to 00");
    set_time(41, 12, 31, 23, 59, 59); tick(1); snap_check("R4 month 12 wrap");

    // R5 writes ignored while running
    set_time(30, 7, 7, 7, 7, 7);
    wr(5'h00, 8'h33); wr(5'h03, 8'h22);
    snap_check("R5 running write ignored");

    // R6 latch holds across ticks, R7 self clear
    snap_check("R6 capture");
    t0 = model_bcd();
    tick(3);
    rd_time(t); chk("R6 latch holds", t, t0);
    rd(5'h10, b); chk("R7 get cleared, run kept", 48'(b), 48'h01);

    // R8 alarm readback and flag, R10 irq
    set_time(24, 6, 15, 12, 30, 45);
    wr(5'h08, 8'h47); wr(5'h09, 8'h30); wr(5'h0A, 8'h12);
    wr(5'h0B, 8'h15); wr(5'h0C, 8'h06); wr(5'h0D, 8'h24);
    wr(5'h12, 8'h01);
    rd(5'h08, b); chk("R8 alarm readback sec", 48'(b), 48'h47);
    rd(5'h0D, b); chk("R8 alarm readback year", 48'(b), 48'h24);
    tick(1);
    rd(5'h11, b); chk("R8 no early flag", 48'(b), 48'h00);
    tick(1); @(negedge clk);
    rd(5'h11, b); chk("R8 flag on match", 48'(b), 48'h01);
    chk("R10 irq asserted", 48'(irq_n), 48'h0);
    // R9 clear semantics
    wr(5'h11, 8'h00);
    rd(5'h11, b); chk("R9 write 0 keeps flag", 48'(b), 48'h01);
    wr(5'h11, 8'h01);
    rd(5'h11, b); chk("R9 write 1 clears", 48'(b), 48'h00);
    chk("R10 irq released", 48'(irq_n), 48'h1);
    tick(2);
    rd(5'h11, b); chk("R9 no re-set without new match", 48'(b), 48'h00);
    // R10 disabled interrupt
    wr(5'h12, 8'h00);
    wr(5'h08, b2bcd(m_s + 1));
    tick(1); @(negedge clk);
    rd(5'h11, b); chk("R10 flag sets with irq disabled", 48'(b), 48'h01);
    chk("R10 irq stays high when disabled", 48'(irq_n), 48'h1);
    wr(5'h11, 8'h01);

    // R2/R3/R4 random
    begin
      int unsigned seed = 32'd12345;
      int r;
      r = $urandom(seed);
      for (int k = 0; k < 24; k++) begin
        int y = $urandom % 100;
        int mo = 1 + $urandom % 12;
        int d = ($urandom % 2) ? mdays(mo, y) : 1 + $urandom % mdays(mo, y);
        int h = ($urandom % 2) ? 23 : $urandom % 24;
        int mi = ($urandom % 2) ? 59 : $urandom % 60;
        int s = 30 + $urandom % 30;
        if (k == 23) mo = 12;
        if (k == 23) d = 31;
        set_time(y, mo, d, h, mi, s);
        tick(1 + $urandom % 60);
        snap_check("R2 R3 R4 random walk");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule